// File: doc/BRIEF.md
# Reader Interrupt Status Controller

This block sits beside the digital core of a contactless reader and turns its event pulses into one active-high interrupt request for a host. Transmit start, transmit end, receive start-of-frame, FIFO level, CRC error, parity error and framing error each arrive as a single-cycle pulse. Six of them latch a flag of their own. The seventh flag is raised by an internal no-response timer.

Each source has an enable bit, and the request line is the OR of all enabled flags. There is one exception. The transmit flag is latched when a transfer starts, but it does not reach the request line until that transfer has ended. Each time a transmission ends, the no-response timer is reloaded from a wait value. A receive start-of-frame stops the timer. If the timer runs out, it sets the timeout flag.

The host finds the cause of an interrupt by reading the status word. That read also clears every flag. An event that arrives in the same cycle as the read is not lost.

Top module: `rdr_irq_ctrl`

## Requirements
- R1: While `rst` is high, all flags clear and `irq` is 0. After reset, every enable bit is 1.
- R2: An event pulse sampled at a rising edge sets its flag from that edge onward. The flag positions in `stat_q` are: bit 0 transmit, bit 1 receive start-of-frame, bit 2 FIFO, bit 3 CRC error, bit 4 parity error, bit 5 framing error, bit 6 no-response timeout.
- R3: The transmit flag sets on `tx_start`. It adds to `irq` only after a `tx_end` has been sampled for that transfer.
- R4: `irq` is the OR of flag AND enable over all seven sources, with the transmit term gated as in R3. A flag whose enable is 0 still latches but does not raise `irq`.
- R5: `stat_q` always shows the current flags. A cycle with `stat_rd` high clears every flag at the next edge, except a flag whose event is sampled at that same edge, which stays set.
- R6: After `tx_end` is sampled with `wait_cycles` = N > 0, and if no `rx_sof` follows, bit 6 sets exactly N rising edges later.
- R7: An `rx_sof` sampled while the timer is running cancels it, and no timeout flag follows.
- R8: When `wait_cycles` is 0 at `tx_end`, the timer does not start and no timeout occurs.
- R9: A write with `en_we` replaces all enables with `en_wdata` (same bit positions as R2). The new mask acts on `irq` from the next cycle.
- R10: A `tx_end` sampled while the timer is running restarts the count from the current `wait_cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Transmission started pulse |
| tx_end | input | 1 | Transmission finished pulse |
| rx_sof | input | 1 | Receive start-of-frame pulse |
| fifo_ev | input | 1 | FIFO level event pulse |
| crc_err | input | 1 | CRC error pulse |
| par_err | input | 1 | Parity error pulse |
| frm_err | input | 1 | Framing or end-of-frame error pulse |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 7 | New enable mask |
| wait_cycles | input | TW (16) | No-response wait, in clock cycles |
| stat_rd | input | 1 | Host status read (read-and-clear) |
| stat_q | output | 7 | Current latched flags |
| irq | output | 1 | Interrupt request to host |

## Verification
Each event appears in `stat_q` one edge after it is sampled. `irq` follows the flags and enables combinationally, so it is due in the same cycle as the flag. A read-and-clear takes effect one edge after `stat_rd`. A timeout is due N edges after the `tx_end` edge. The bench drives inputs on falling edges and samples after the following rising edge. In the timer tests it counts edges from the `tx_end` edge and checks bit 6 at every edge up to the Nth.

// File: rtl/rdr_irq_pkg.sv
package rdr_irq_pkg;
    localparam int NSRC = 7;

    typedef enum logic [2:0] {
        SRC_TX     = 3'd0,
        SRC_RXSOF  = 3'd1,
        SRC_FIFO   = 3'd2,
        SRC_CRC    = 3'd3,
        SRC_PAR    = 3'd4,
        SRC_FRM    = 3'd5,
        SRC_NORESP = 3'd6
    } src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic tx_start;
        logic tx_end;
        logic rx_sof;
        logic fifo;
        logic crc;
        logic par;
        logic frm;
    } core_ev_t;

    function automatic src_vec_t src_bit(input src_e s);
        src_vec_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic src_vec_t pack_events(input core_ev_t e, input logic tmo);
        src_vec_t v;
        v = '0;
        v[SRC_TX]     = e.tx_start;
        v[SRC_RXSOF]  = e.rx_sof;
        v[SRC_FIFO]   = e.fifo;
        v[SRC_CRC]    = e.crc;
        v[SRC_PAR]    = e.par;
        v[SRC_FRM]    = e.frm;
        v[SRC_NORESP] = tmo;
        return v;
    endfunction
endpackage

// File: rtl/rdr_irq_timer.sv
module rdr_irq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_end,
    input  logic          rx_sof,
    input  logic [TW-1:0] wait_cycles,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic          active;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (tx_end) begin
            active <= (wait_cycles != '0);
            cnt    <= wait_cycles;
        end else if (rx_sof) begin
            active <= 1'b0;
        end else if (active) begin
            if (cnt == ONE) active <= 1'b0;
            else            cnt    <= cnt - ONE;
        end
    end

    assign expire = active && (cnt == ONE) && !rx_sof && !tx_end;

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_end && wait_cycles != '0) |=> (active && cnt == $past(wait_cycles)));
    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_sof && !tx_end) |=> !active);
    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_end && wait_cycles == '0) |=> !active);
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_end && active && wait_cycles != '0) |=> (cnt == $past(wait_cycles)));
endmodule

// File: rtl/rdr_irq_flags.sv
module rdr_irq_flags
    import rdr_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t set_vec,
    input  logic     tx_start,
    input  logic     tx_end,
    input  logic     clr,
    input  logic     en_we,
    input  src_vec_t en_wdata,
    output src_vec_t flags,
    output src_vec_t enables,
    output logic     tx_busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '1;
            tx_busy <= 1'b0;
        end else begin
            flags <= (clr ? '0 : flags) | set_vec;
            if (en_we) enables <= en_wdata;
            if (tx_start)    tx_busy <= 1'b1;
            else if (tx_end) tx_busy <= 1'b0;
        end
    end

    p_rst_r1: assert property (@(posedge clk)
        rst |=> (flags == '0 && enables == '1 && !tx_busy));
    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && set_vec == '0) |=> (flags == '0));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> ((flags & $past(flags)) == $past(flags)));
    p_enwr_r9: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (enables == $past(en_wdata)));
endmodule

// File: rtl/rdr_irq_ctrl.sv
module rdr_irq_ctrl
    import rdr_irq_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_start,
    input  logic            tx_end,
    input  logic            rx_sof,
    input  logic            fifo_ev,
    input  logic            crc_err,
    input  logic            par_err,
    input  logic            frm_err,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    input  logic [TW-1:0]   wait_cycles,
    input  logic            stat_rd,
    output logic [NSRC-1:0] stat_q,
    output logic            irq
);
    core_ev_t ev;
    logic     tmo;
    src_vec_t set_vec, flags, enables, gate, live;
    logic     tx_busy;

    assign ev = '{tx_start: tx_start, tx_end: tx_end, rx_sof: rx_sof,
                  fifo: fifo_ev, crc: crc_err, par: par_err, frm: frm_err};

    rdr_irq_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .tx_end(tx_end), .rx_sof(rx_sof),
        .wait_cycles(wait_cycles), .expire(tmo)
    );

    assign set_vec = pack_events(ev, tmo);

    rdr_irq_flags u_flags (
        .clk(clk), .rst(rst), .set_vec(set_vec), .tx_start(tx_start),
        .tx_end(tx_end), .clr(stat_rd), .en_we(en_we), .en_wdata(en_wdata),
        .flags(flags), .enables(enables), .tx_busy(tx_busy)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        if (i == int'(SRC_TX)) begin : g_tx
            assign gate[i] = !tx_busy;
        end else begin : g_other
            assign gate[i] = 1'b1;
        end
    end

    assign live   = flags & enables & gate;
    assign irq    = |live;
    assign stat_q = flags;

    p_irq_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & enables) != '0));
    p_txhold_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !tx_end) |=> !(live[SRC_TX]));
    p_rstirq_r1: assert property (@(posedge clk) rst |=> !irq);
    p_tmo_r6: assert property (@(posedge clk) disable iff (rst)
        tmo |=> stat_q[SRC_NORESP]);
endmodule

// File: tb/rdr_irq_ctrl_test.sv
module rdr_irq_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_start = 0, tx_end = 0, rx_sof = 0, fifo_ev = 0;
    logic crc_err = 0, par_err = 0, frm_err = 0, en_we = 0, stat_rd = 0;
    logic [6:0]  en_wdata = '1;
    logic [15:0] wait_cycles = '0;
    logic [6:0]  stat_q;
    logic        irq;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    rdr_irq_ctrl #(.TW(16)) uut (
        .clk(clk), .rst(rst), .tx_start(tx_start), .tx_end(tx_end),
        .rx_sof(rx_sof), .fifo_ev(fifo_ev), .crc_err(crc_err),
        .par_err(par_err), .frm_err(frm_err), .en_we(en_we),
        .en_wdata(en_wdata), .wait_cycles(wait_cycles), .stat_rd(stat_rd),
        .stat_q(stat_q), .irq(irq)
    );

    // vector: {ev[6:0], rd, exp_q[6:0], exp_irq}
    // ev bits: 0 tx_start, 1 tx_end, 2 rx_sof, 3 fifo, 4 crc, 5 par, 6 frm
    localparam logic [15:0] VEC [13] = '{
        {7'h00, 1'b0, 7'h00, 1'b0},
        {7'h01, 1'b0, 7'h00, 1'b0},
        {7'h00, 1'b0, 7'h01, 1'b0},
        {7'h02, 1'b0, 7'h01, 1'b0},
        {7'h00, 1'b0, 7'h01, 1'b1},
        {7'h00, 1'b1, 7'h01, 1'b1},
        {7'h10, 1'b0, 7'h00, 1'b0},
        {7'h20, 1'b1, 7'h08, 1'b1},
        {7'h00, 1'b1, 7'h10, 1'b1},
        {7'h0C, 1'b0, 7'h00, 1'b0},
        {7'h40, 1'b0, 7'h06, 1'b1},
        {7'h00, 1'b1, 7'h26, 1'b1},
        {7'h00, 1'b0, 7'h00, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] e, input logic rd);
        {frm_err, par_err, crc_err, fifo_ev, rx_sof, tx_end, tx_start} = e;
        stat_rd = rd;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(7'h00, 1'b0);
        en_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset stat", 32'(stat_q), 0);
        chk("R1 reset irq", 32'(irq), 0);

        for (int i = 0; i < 13; i++) begin
            drive(VEC[i][15:9], VEC[i][8]);
            #1;
            chk($sformatf("R2/R3/R5 vec%0d stat", i), 32'(stat_q), 32'(VEC[i][7:1]));
            chk($sformatf("R3/R4 vec%0d irq", i), 32'(irq), 32'(VEC[i][0]));
            step();
        end

        // R1: reset mid-operation clears flags and irq
        drive(7'h50, 1'b0); step();
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1 mid reset stat", 32'(stat_q), 0);
        chk("R1 mid reset irq", 32'(irq), 0);

        // R4/R9: masked CRC latches without irq, unmask raises irq
        en_we = 1'b1; en_wdata = 7'h77; step();
        drive(7'h10, 1'b0); step();
        chk("R4 masked flag", 32'(stat_q), 32'h08);
        chk("R4 masked irq", 32'(irq), 0);
        en_we = 1'b1; en_wdata = 7'h7F; step();
        chk("R9 unmask irq", 32'(irq), 1);
        drive(7'h00, 1'b1); step();
        chk("R5 cleared", 32'(stat_q), 0);

        // R6: timeout N=5 edges after tx_end
        wait_cycles = 16'd5;
        drive(7'h02, 1'b0);
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            drive(7'h00, 1'b0);
            chk($sformatf("R6 early edge%0d", k), 32'(stat_q[6]), 0);
            @(posedge clk);
        end
        @(negedge clk);
        chk("R6 timeout flag", 32'(stat_q[6]), 1);
        chk("R6 timeout irq", 32'(irq), 1);
        drive(7'h00, 1'b1); step();

        // R7: start-of-frame cancels the timer
        drive(7'h02, 1'b0); step(); step();
        drive(7'h04, 1'b0); step();
        for (int k = 0; k < 10; k++) step();
        chk("R7 cancelled", 32'(stat_q[6]), 0);
        drive(7'h00, 1'b1); step();

        // R10: second tx_end restarts the count
        drive(7'h02, 1'b0); step(); step(); step();
        drive(7'h02, 1'b0); step();
        step(); step();
        chk("R10 old deadline", 32'(stat_q[6]), 0);
        step(); step();
        chk("R10 before new deadline", 32'(stat_q[6]), 0);
        step();
        chk("R10 new deadline", 32'(stat_q[6]), 1);
        drive(7'h00, 1'b1); step();

        // R8: zero wait never times out
        wait_cycles = 16'd0;
        drive(7'h02, 1'b0); step();
        for (int k = 0; k < 20; k++) step();
        chk("R8 no timeout", 32'(stat_q[6]), 0);
        chk("R8 irq low", 32'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule